// File: doc/BRIEF.md
# Multiplexed Bus Cycle Demultiplexer

This block sits between a small processor and its memory and I/O ports. The processor shares one 8-bit bus for address and data. It reports its current bus state on a 3-bit status code, and a state strobe marks each clock in which that code is valid. The block captures the address bytes as they pass on the bus. In the high-address state, the two top bus bits give the kind of cycle; the block keeps them and rebuilds a 14-bit address from the two captured bytes.

In the data-transfer state the block produces one of four kinds of action. For a memory cycle it raises a read or a write strobe. For an I/O command cycle it raises one pulse on a one-hot input-port or output-port strobe, chosen by the captured port number. Read data is sent back toward the processor through a driver enable and a data output. The processor's bus is bidirectional, so that enable controls an external tristate buffer.

A wait-state count makes the ready output hold the processor in its wait state for a chosen number of states on every memory access.

Top module: `bus_cycle_demux`

## Requirements
- R1: On a state-strobe clock with status 010 or 110 (both are low-address states), the bus byte is captured as address bits 7..0. The captured value appears on `addr` from the next clock onward.
- R2: On a state-strobe clock with status 100 (high-address state), two things are captured. Bus bits 5..0 become address bits 13..8. Bus bit 7 and bus bit 6 become `cycType[1]` and `cycType[0]`.
- R3: The cycle-type codes are 00 fetch, 10 memory read, 11 memory write and 01 I/O command. In a data-transfer state (status 001 with the state strobe high), `memRd` is high for fetch or memory read, and `memWr` is high for memory write. `wrData` carries the bus byte. `memRd` and `memWr` are never high together.
- R4: `busOe` is high only in a data-transfer state, and only for one of these cases:
  - a fetch or a memory read, where `busOut` equals `memRdData`;
  - an I/O input-port command, where `busOut` equals `ioRdData`.
- R5: In an I/O data-transfer state, the port number is address bits 4..0. Other address bits have no effect on the port choice.
  - Port numbers 0..7, where bits 4..3 are 00, pulse `inStrobe[port]`.
  - Port numbers 8..31 pulse `outStrobe[port-8]`.
  - Exactly one strobe bit is high for that state. No port strobe is high at any other time.
- R6: A high-address state of a memory cycle (fetch, read or write) loads the wait count from `waitStates`. `readyOut` is then low until that many wait states (status 000 with the state strobe high) have passed. An I/O command cycle, or a wait count of zero, leaves `readyOut` high.
- R7: While the state strobe is low, the status code and the bus byte are ignored. Nothing is captured and no strobe or driver enable is raised.
- R8: The states 011, 101, 111 and 000 raise no strobe, no driver enable, and leave the captured address unchanged.
- R9: After reset, `addr` is 0, `cycType` is 00 and `readyOut` is high. All strobes and `busOe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stateTick | input | 1 | Status code is valid for this clock |
| status | input | 3 | Processor bus state code |
| busIn | input | 8 | Byte the processor drives on the shared bus |
| memRdData | input | 8 | Data returned by memory |
| ioRdData | input | 8 | Data returned by the selected input port |
| waitStates | input | 4 | Wait states inserted per memory access |
| addr | output | 14 | Rebuilt address |
| cycType | output | 2 | Captured cycle type |
| busOut | output | 8 | Byte to drive toward the processor |
| busOe | output | 1 | Enable for the external bus driver |
| memRd | output | 1 | Memory read strobe (fetch or read) |
| memWr | output | 1 | Memory write strobe |
| wrData | output | 8 | Write data for memory or output ports |
| inStrobe | output | 8 | One-hot input-port strobe |
| outStrobe | output | 24 | One-hot output-port strobe |
| readyOut | output | 1 | Ready toward the processor |

## Verification
The bench builds the block with its defaults: a 14-bit address, 8 input ports and 24 output ports, and a 4-bit wait count. These values make every port number reachable, including the 7/8 boundary between input and output ports and the last output port, 31. They also make the top address 3FFF reachable, and the longest wait of 15 states, which a random processor-model sequence can exercise.

// File: rtl/bus_demux_pkg.sv
package bus_demux_pkg;

  typedef enum logic [2:0] {
    ST_WAIT   = 3'b000,
    ST_XFER   = 3'b001,
    ST_ADRLO  = 3'b010,
    ST_HALT   = 3'b011,
    ST_ADRHI  = 3'b100,
    ST_EXT5   = 3'b101,
    ST_ADRLOI = 3'b110,
    ST_EXT4   = 3'b111
  } procState_e;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_IO    = 2'b01,
    CYC_READ  = 2'b10,
    CYC_WRITE = 2'b11
  } cycKind_e;

  typedef struct packed {
    logic latchLo;
    logic latchHi;
    logic xfer;
  } ctlStrobes_t;

endpackage

// File: rtl/bus_demux_ctl.sv
module bus_demux_ctl
  import bus_demux_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stateTick,
  input  logic [2:0]        status,
  input  logic [1:0]        ccIn,
  input  logic [WAIT_W-1:0] waitStates,
  output ctlStrobes_t       strobes,
  output logic              readyOut
);

  procState_e          curState;
  logic [WAIT_W-1:0]   waitCnt;
  logic                memCycle;

  always_comb begin
    curState        = procState_e'(status);
    strobes.latchLo = stateTick && (curState == ST_ADRLO || curState == ST_ADRLOI);
    strobes.latchHi = stateTick && (curState == ST_ADRHI);
    strobes.xfer    = stateTick && (curState == ST_XFER);
    memCycle        = (cycKind_e'(ccIn) != CYC_IO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobes.latchHi) begin
      waitCnt <= memCycle ? waitStates : '0;
    end else if (strobes.xfer) begin
      waitCnt <= '0;
    end else if (stateTick && curState == ST_WAIT && waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign readyOut = (waitCnt == '0);

endmodule

// File: rtl/bus_demux_dp.sv
module bus_demux_dp
  import bus_demux_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 14,
  parameter int IN_PORTS  = 8,
  parameter int OUT_PORTS = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  logic [DATA_W-1:0]    busIn,
  input  logic [DATA_W-1:0]    memRdData,
  input  logic [DATA_W-1:0]    ioRdData,
  output logic [ADDR_W-1:0]    addr,
  output logic [1:0]           cycType,
  output logic [DATA_W-1:0]    busOut,
  output logic                 busOe,
  output logic                 memRd,
  output logic                 memWr,
  output logic [DATA_W-1:0]    wrData,
  output logic [IN_PORTS-1:0]  inStrobe,
  output logic [OUT_PORTS-1:0] outStrobe
);

  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int PORT_W = $clog2(IN_PORTS + OUT_PORTS);

  logic [DATA_W-1:0] loByte;
  logic [HI_W-1:0]   hiBits;
  cycKind_e          cycReg;
  logic [PORT_W-1:0] portNum;
  logic              ioXfer;
  logic              portIsIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loByte <= '0;
      hiBits <= '0;
      cycReg <= CYC_FETCH;
    end else begin
      if (strobes.latchLo) loByte <= busIn;
      if (strobes.latchHi) begin
        hiBits <= busIn[HI_W-1:0];
        cycReg <= cycKind_e'(busIn[DATA_W-1 -: 2]);
      end
    end
  end

  always_comb begin
    addr     = {hiBits, loByte};
    cycType  = cycReg;
    portNum  = loByte[PORT_W-1:0];
    portIsIn = (portNum < PORT_W'(IN_PORTS));
    memRd    = strobes.xfer && (cycReg == CYC_FETCH || cycReg == CYC_READ);
    memWr    = strobes.xfer && (cycReg == CYC_WRITE);
    ioXfer   = strobes.xfer && (cycReg == CYC_IO);
    busOe    = memRd || (ioXfer && portIsIn);
    busOut   = !busOe ? '0 : (memRd ? memRdData : ioRdData);
    wrData   = busIn;
  end

  for (genvar i = 0; i < IN_PORTS; i++) begin : g_inPort
    assign inStrobe[i] = ioXfer && (portNum == PORT_W'(i));
  end

  for (genvar j = 0; j < OUT_PORTS; j++) begin : g_outPort
    assign outStrobe[j] = ioXfer && (portNum == PORT_W'(IN_PORTS + j));
  end

endmodule

// File: rtl/bus_cycle_demux.sv
module bus_cycle_demux
  import bus_demux_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 14,
  parameter int WAIT_W    = 4,
  parameter int IN_PORTS  = 8,
  parameter int OUT_PORTS = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stateTick,
  input  logic [2:0]           status,
  input  logic [DATA_W-1:0]    busIn,
  input  logic [DATA_W-1:0]    memRdData,
  input  logic [DATA_W-1:0]    ioRdData,
  input  logic [WAIT_W-1:0]    waitStates,
  output logic [ADDR_W-1:0]    addr,
  output logic [1:0]           cycType,
  output logic [DATA_W-1:0]    busOut,
  output logic                 busOe,
  output logic                 memRd,
  output logic                 memWr,
  output logic [DATA_W-1:0]    wrData,
  output logic [IN_PORTS-1:0]  inStrobe,
  output logic [OUT_PORTS-1:0] outStrobe,
  output logic                 readyOut
);

  ctlStrobes_t strobes;

  bus_demux_ctl #(.WAIT_W(WAIT_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .stateTick  (stateTick),
    .status     (status),
    .ccIn       (busIn[DATA_W-1 -: 2]),
    .waitStates (waitStates),
    .strobes    (strobes),
    .readyOut   (readyOut)
  );

  bus_demux_dp #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .IN_PORTS  (IN_PORTS),
    .OUT_PORTS (OUT_PORTS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busIn     (busIn),
    .memRdData (memRdData),
    .ioRdData  (ioRdData),
    .addr      (addr),
    .cycType   (cycType),
    .busOut    (busOut),
    .busOe     (busOe),
    .memRd     (memRd),
    .memWr     (memWr),
    .wrData    (wrData),
    .inStrobe  (inStrobe),
    .outStrobe (outStrobe)
  );

endmodule

// File: rtl/bus_cycle_demux_chk.sv
module bus_cycle_demux_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 14,
  parameter int WAIT_W    = 4,
  parameter int IN_PORTS  = 8,
  parameter int OUT_PORTS = 24
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 stateTick,
  input logic [2:0]           status,
  input logic [DATA_W-1:0]    busIn,
  input logic [WAIT_W-1:0]    waitStates,
  input logic [ADDR_W-1:0]    addr,
  input logic                 busOe,
  input logic                 memRd,
  input logic                 memWr,
  input logic [IN_PORTS-1:0]  inStrobe,
  input logic [OUT_PORTS-1:0] outStrobe,
  input logic                 readyOut
);

  p_rdwr_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  p_oe_xfer_r4: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (stateTick && status == 3'b001));

  p_port_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inStrobe, outStrobe}));

  p_port_no_mem_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|{inStrobe, outStrobe}) |-> !(memRd || memWr));

  p_ready_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateTick && status == 3'b100 && busIn[DATA_W-1 -: 2] != 2'b01 && waitStates != '0)
      |=> !readyOut);

  p_ready_io_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateTick && status == 3'b100 && busIn[DATA_W-1 -: 2] == 2'b01) |=> readyOut);

  // R7 and R8: only a strobed address state may move the address
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(stateTick && (status == 3'b010 || status == 3'b110 || status == 3'b100))
      |=> $stable(addr));

  p_strobe_xfer_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr || (|inStrobe) || (|outStrobe)) |-> (stateTick && status == 3'b001));

endmodule

bind bus_cycle_demux bus_cycle_demux_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .WAIT_W    (WAIT_W),
  .IN_PORTS  (IN_PORTS),
  .OUT_PORTS (OUT_PORTS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stateTick  (stateTick),
  .status     (status),
  .busIn      (busIn),
  .waitStates (waitStates),
  .addr       (addr),
  .busOe      (busOe),
  .memRd      (memRd),
  .memWr      (memWr),
  .inStrobe   (inStrobe),
  .outStrobe  (outStrobe),
  .readyOut   (readyOut)
);

// File: tb/bus_cycle_demux_bench.sv
module bus_cycle_demux_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stateTick = 1'b0;
  logic [2:0]  status = 3'b000;
  logic [7:0]  busIn = 8'h00;
  logic [7:0]  memRdData = 8'h00;
  logic [7:0]  ioRdData = 8'h00;
  logic [3:0]  waitStates = 4'h0;
  logic [13:0] addr;
  logic [1:0]  cycType;
  logic [7:0]  busOut;
  logic        busOe;
  logic        memRd;
  logic        memWr;
  logic [7:0]  wrData;
  logic [7:0]  inStrobe;
  logic [23:0] outStrobe;
  logic        readyOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bus_cycle_demux u_bus_cycle_demux (
    .clk(clk), .rstN(rstN), .stateTick(stateTick), .status(status),
    .busIn(busIn), .memRdData(memRdData), .ioRdData(ioRdData),
    .waitStates(waitStates), .addr(addr), .cycType(cycType),
    .busOut(busOut), .busOe(busOe), .memRd(memRd), .memWr(memWr),
    .wrData(wrData), .inStrobe(inStrobe), .outStrobe(outStrobe),
    .readyOut(readyOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] activity();
    return {memRd, memWr, busOe, |inStrobe, |outStrobe};
  endfunction

  function automatic logic [7:0] expIn(input logic [1:0] cc, input logic [4:0] port);
    return (cc == 2'b01 && port < 5'd8) ? (8'b1 << port[2:0]) : 8'h00;
  endfunction

  function automatic logic [23:0] expOut(input logic [1:0] cc, input logic [4:0] port);
    return (cc == 2'b01 && port >= 5'd8) ? (24'b1 << (port - 5'd8)) : 24'h0;
  endfunction

  task automatic step(input logic [2:0] st, input logic [7:0] b, input logic tk);
    @(negedge clk);
    status = st;
    busIn = b;
    stateTick = tk;
    #1;
  endtask

  task automatic runCycle(input logic [13:0] a, input logic [1:0] cc, input logic [7:0] d,
                          input logic [3:0] nw, input bit useT1I);
    int expWaits;
    logic expRd, expInPort;
    waitStates = nw;
    memRdData = 8'($urandom);
    ioRdData = 8'($urandom);
    step(useT1I ? 3'b110 : 3'b010, a[7:0], 1'b1);
    chk("R8 no activity in low-address state", activity(), 5'h0);
    step(3'b100, {cc, a[13:8]}, 1'b1);
    chk("R1 low byte captured", addr[7:0], a[7:0]);
    chk("R8 no activity in high-address state", activity(), 5'h0);
    expWaits = (cc == 2'b01) ? 0 : int'(nw);
    for (int k = 0; k < expWaits; k++) begin
      step(3'b000, 8'($urandom), 1'b1);
      chk("R6 ready low during wait", readyOut, 1'b0);
      chk("R8 no activity in wait state", activity(), 5'h0);
    end
    step(3'b001, d, 1'b1);
    expRd = (cc == 2'b00 || cc == 2'b10);
    expInPort = (cc == 2'b01 && a[4:3] == 2'b00);
    chk("R6 ready high at transfer", readyOut, 1'b1);
    chk("R2 address rebuilt", addr, a);
    chk("R2 cycle type", cycType, cc);
    chk("R3 memRd", memRd, expRd);
    chk("R3 memWr", memWr, cc == 2'b11);
    chk("R3 wrData", wrData, d);
    chk("R4 busOe", busOe, expRd || expInPort);
    if (expRd) chk("R4 busOut memory data", busOut, memRdData);
    else if (expInPort) chk("R4 busOut port data", busOut, ioRdData);
    chk("R5 inStrobe", inStrobe, expIn(cc, a[4:0]));
    chk("R5 outStrobe", outStrobe, expOut(cc, a[4:0]));
    step(($urandom % 2) ? 3'b111 : 3'b101, 8'($urandom), 1'b1);
    chk("R8 no activity after transfer", activity(), 5'h0);
    chk("R8 address held", addr, a);
  endtask

  task automatic idleCheck();
    logic [13:0] held;
    held = addr;
    step(3'b010, 8'($urandom), 1'b0);
    chk("R7 no activity without state strobe", activity(), 5'h0);
    step(3'b001, 8'($urandom), 1'b0);
    chk("R7 transfer ignored without state strobe", activity(), 5'h0);
    step(3'b011, 8'($urandom), 1'b1);
    chk("R7 address kept without state strobe", addr, held);
    chk("R8 no activity in stopped state", activity(), 5'h0);
  endtask

  initial begin
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset addr", addr, 14'h0);
    chk("R9 reset cycType", cycType, 2'b00);
    chk("R9 reset ready", readyOut, 1'b1);
    chk("R9 reset activity", activity(), 5'h0);
    @(negedge clk);
    rstN = 1'b1;

    runCycle(14'h3FFF, 2'b11, 8'hA5, 4'd15, 1'b0);
    runCycle(14'h0000, 2'b00, 8'h00, 4'd0, 1'b1);
    runCycle(14'h1234, 2'b10, 8'h3C, 4'd1, 1'b0);
    runCycle(14'h2A00, 2'b01, 8'h11, 4'd9, 1'b0);
    runCycle(14'h0007, 2'b01, 8'h22, 4'd3, 1'b1);
    runCycle(14'h0008, 2'b01, 8'h33, 4'd0, 1'b0);
    runCycle(14'h00FF, 2'b01, 8'h44, 4'd0, 1'b0);
    runCycle(14'h00E5, 2'b01, 8'h55, 4'd2, 1'b0);
    idleCheck();

    for (int n = 0; n < 400; n++) begin
      runCycle(14'($urandom), 2'($urandom), 8'($urandom),
               ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 3), 1'($urandom));
      if ($urandom % 6 == 0) idleCheck();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule